// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side master for a write-only, three-wire serial link to a 12-bit voltage-output converter. A client offers a 12-bit output code and a 2-bit power mode over a valid/ready handshake. Once a request is taken, the block raises the frame-select line for a programmable guard time. It then drops the line and clocks out a 16-bit word, most significant bit first. The serial clock comes from the system clock through a programmable half-period count. After the last bit the select line goes high again for the guard time and then rests low, which is the low-power idle level.

The serial clock rests low. Data moves only on rising serial-clock edges, so the receiver, which samples on falling edges, always sees a settled bit. A one-cycle done pulse marks the sixteenth falling edge. Both the serial-clock rate and the guard time are parameters counted in system clock cycles. The integrator picks them to keep the clock at or below 20 MHz (lower supply) or 30 MHz (higher supply), and the select-high time at or above 33 ns.

Top module: `dac_frame_writer`

## Requirements
- R1: While reset is asserted, ser_sync, ser_clk, ser_data, busy and done are 0 and req_ready is 1.
- R2: The word is sampled on falling ser_clk edges, most significant bit first. Bits 15:14 are 0, bits 13:12 carry req_mode and bits 11:0 carry req_code.
- R3: A request is taken only at a clock edge where req_valid and req_ready are both 1. A request offered and withdrawn while req_ready is 0 starts no frame.
- R4: The cycle after acceptance, ser_sync is 1. It stays 1 for exactly GAP_CYC cycles and then falls while ser_clk is 0. The first rising ser_clk edge comes HALF_CYC cycles after that fall.
- R5: ser_clk toggles only while ser_sync is 0. Each level lasts exactly HALF_CYC cycles, and a frame has exactly 16 falling edges.
- R6: ser_data changes only in a cycle where ser_clk rises or while ser_clk is low. It never changes at a falling edge or while ser_clk stays high.
- R7: ser_sync stays low for HALF_CYC cycles after the 16th falling edge. It then rises while ser_clk is 0, stays high for exactly GAP_CYC cycles, and returns to 0.
- R8: done is a single-cycle pulse that coincides with the 16th falling edge, GAP_CYC + 32*HALF_CYC cycles after acceptance.
- R9: From acceptance, busy is 1 and req_ready is 0 for exactly 2*GAP_CYC + 33*HALF_CYC cycles. In idle, ser_sync and ser_clk are 0.
- R10: If req_valid is held high, the next request is taken on the first idle cycle. ser_sync is then low for exactly one cycle between the trailing and leading high pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_code | input | CODE_W | Output code to send |
| req_mode | input | MODE_W | Power mode bits to send |
| ser_sync | output | 1 | Frame select to the converter |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, changes on rising ser_clk |
| busy | output | 1 | A frame or its guard time is in progress |
| done | output | 1 | One-cycle pulse at the 16th falling edge |

## Verification
Two events can fall in the same cycle. The first is the return to idle after the trailing select pulse. The second is the acceptance of the next request, which raises select again at once. The bench provokes this by holding req_valid high with a new code while a frame finishes. It then checks three things: the low gap between the two select pulses is exactly one cycle, both words arrive intact, and the guard timing of each frame holds. The bench also checks that the done pulse lands in the same cycle as the sixteenth falling clock edge.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_END   = 3'd3,
      ST_TAIL  = 3'd4
   } wr_state_t;

endpackage

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
   parameter int TMR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             zero
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/dac_wr_shifter.sv
module dac_wr_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               shift,
   input  logic               clr,
   output logic               msb_out
);

   logic [FRAME_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= frame_in;
      end else if (clr) begin
         sr_q <= '0;
      end else if (shift) begin
         sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign msb_out = sr_q[FRAME_W-1];

endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
   import dac_wr_pkg::*;
#(
   parameter int CODE_W   = 12,
   parameter int MODE_W   = 2,
   parameter int PAD_W    = 2,
   parameter int HALF_CYC = 4,
   parameter int GAP_CYC  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CODE_W-1:0] req_code,
   input  logic [MODE_W-1:0] req_mode,
   output logic              ser_sync,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              busy,
   output logic              done
);

   localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int TMR_MAX = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(GAP_CYC - 1);
   localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_W - 1);

   // elaboration-time parameter checks
   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end
   if (CODE_W < 1 || MODE_W < 1 || PAD_W < 0) begin : g_bad_width
      $error("field widths out of range");
   end

   // frame assembly: pad bits (if any) are driven as zero
   logic [FRAME_W-1:0] frame_word;
   if (PAD_W > 0) begin : g_pad
      assign frame_word = {{PAD_W{1'b0}}, req_mode, req_code};
   end else begin : g_nopad
      assign frame_word = {req_mode, req_code};
   end

   wr_state_t        state_q;
   logic             sync_q;
   logic             sclk_q;
   logic             done_q;
   logic [CNT_W-1:0] fall_q;

   logic             accept;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             sh_shift;
   logic             sh_clr;
   logic             sh_msb;

   assign accept = req_valid && (state_q == ST_IDLE);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_shift = 1'b0;
      sh_clr   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               tmr_val  = GAP_LD;
            end
         end
         ST_LEAD: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = HALF_LD;
            end
         end
         ST_SHIFT: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = HALF_LD;
               // advance data only on rising edges after the first bit
               sh_shift = !sclk_q && (fall_q != '0);
            end
         end
         ST_END: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = GAP_LD;
               sh_clr   = 1'b1;
            end
         end
         default: begin
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sync_q  <= 1'b0;
         sclk_q  <= 1'b0;
         done_q  <= 1'b0;
         fall_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_LEAD;
                  sync_q  <= 1'b1;
               end
            end
            ST_LEAD: begin
               if (tmr_zero) begin
                  state_q <= ST_SHIFT;
                  sync_q  <= 1'b0;
                  fall_q  <= '0;
               end
            end
            ST_SHIFT: begin
               if (tmr_zero) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     fall_q <= fall_q + 1'b1;
                     if (fall_q == LAST_FALL) begin
                        done_q  <= 1'b1;
                        state_q <= ST_END;
                     end
                  end
               end
            end
            ST_END: begin
               if (tmr_zero) begin
                  sync_q  <= 1'b1;
                  state_q <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (tmr_zero) begin
                  sync_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   dac_wr_timer #(.TMR_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   dac_wr_shifter #(.FRAME_W(FRAME_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .frame_in (frame_word),
      .shift    (sh_shift),
      .clr      (sh_clr),
      .msb_out  (sh_msb)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign busy      = (state_q != ST_IDLE);
   assign ser_sync  = sync_q;
   assign ser_clk   = sclk_q;
   assign ser_data  = sh_msb;
   assign done      = done_q;

endmodule

// File: rtl/dac_frame_writer_chk.sv
module dac_frame_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic ser_sync,
   input logic ser_clk,
   input logic ser_data,
   input logic busy,
   input logic done
);

   a_r5_clk_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> !ser_sync);

   a_r6_data_hold_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> $stable(ser_data));

   a_r6_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   a_r4_accept_raises_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ser_sync && busy));

   a_r4_sync_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_sync) |-> !ser_clk);

   a_r7_sync_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_sync) |-> !ser_clk);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(ser_clk) && !ser_sync));

   a_r9_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!ser_sync && !ser_clk));

endmodule

bind dac_frame_writer dac_frame_writer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .ser_sync  (ser_sync),
   .ser_clk   (ser_clk),
   .ser_data  (ser_data),
   .busy      (busy),
   .done      (done)
);

// File: tb/dac_frame_writer_test.sv
module dac_frame_writer_test;

   localparam int H      = 4;
   localparam int G      = 5;
   localparam int T_BUSY = 2 * G + 33 * H;
   localparam int T_DONE = G + 32 * H;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_code = '0;
   logic [1:0]  req_mode = '0;
   logic        ser_sync, ser_clk, ser_data, busy, done;

   int tests = 0;
   int failed = 0;

   always #4 clk = ~clk;

   dac_frame_writer #(.HALF_CYC(H), .GAP_CYC(G)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_code(req_code), .req_mode(req_mode), .ser_sync(ser_sync),
      .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy), .done(done)
   );

   // ---------------- line monitor (samples at posedge, pre-update values)
   logic        p_sync = 1'b0, p_sclk = 1'b0, p_data = 1'b0;
   logic [15:0] cap = '0, last_word = '0;
   int run = 0, falls = 0, hi_run = 0, lo_run = 0;
   int lead_hi = 0, tail_hi = 0, gap_lo = 0, rise_cnt = 0;
   int v_clk = 0, v_data = 0, v_end = 0;
   bit s_rise, s_fall, c_rise, c_fall;

   always @(posedge clk) begin
      if (!rst_n) begin
         run = 0; falls = 0; hi_run = 0; lo_run = 0; cap = '0;
      end else begin
         s_rise = !p_sync && ser_sync;
         s_fall = p_sync && !ser_sync;
         c_rise = !p_sclk && ser_clk;
         c_fall = p_sclk && !ser_clk;
         if ((c_rise || c_fall) && ser_sync) v_clk++;
         if ((ser_data !== p_data) && (c_fall || (p_sclk && ser_clk))) v_data++;
         if (c_fall) begin
            cap = {cap[14:0], p_data};
            falls++;
            if (falls == 16) last_word = cap;
            if (falls > 16) v_clk++;
         end
         if (c_rise || c_fall) begin
            if (run != H) v_clk++;
            run = 1;
         end else if (s_rise && falls == 16) begin
            if (run != H) v_end++;
            run = 1;
         end else if (s_fall) begin
            run = 1;
         end else begin
            run++;
         end
         if (s_rise) begin
            rise_cnt++;
            if (falls == 0) gap_lo = lo_run;
            lo_run = 0;
         end
         if (s_fall) begin
            if (falls == 16) tail_hi = hi_run;
            else lead_hi = hi_run;
            hi_run = 0;
            falls = 0;
            cap = '0;
         end
         if (ser_sync) hi_run++;
         else lo_run++;
      end
      p_sync = ser_sync;
      p_sclk = ser_clk;
      p_data = ser_data;
   end

   // ---------------- helpers
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one frame with full timing checks; hold_next keeps valid high with a new request
   task automatic run_frame(input logic [11:0] code, input logic [1:0] mode,
                            input bit hold_next, input logic [11:0] ncode,
                            input logic [1:0] nmode);
      logic [15:0] exp_word;
      int cnt, done_at, dn, vc0, vd0, ve0;
      exp_word = {2'b00, mode, code};
      vc0 = v_clk; vd0 = v_data; ve0 = v_end;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_code = code; req_mode = mode;
      @(negedge clk);
      if (hold_next) begin
         req_code = ncode; req_mode = nmode;
      end else begin
         req_valid = 1'b0;
      end
      chk(busy && !req_ready, "R9 busy/ready after accept", int'(busy), 1);
      chk(ser_sync, "R4 sync high after accept", int'(ser_sync), 1);
      cnt = 0; done_at = -1; dn = 0;
      while (busy && cnt < 1000) begin
         if (done) begin
            dn++;
            if (done_at < 0) done_at = cnt;
         end
         cnt++;
         @(negedge clk);
      end
      chk(cnt == T_BUSY, "R9 busy length", cnt, T_BUSY);
      chk(done_at == T_DONE, "R8 done position", done_at, T_DONE);
      chk(dn == 1, "R8 done pulse count", dn, 1);
      chk(last_word == exp_word, "R2 frame word", int'(last_word), int'(exp_word));
      chk(lead_hi == G, "R4 leading sync high length", lead_hi, G);
      chk(v_clk == vc0, "R5 sclk timing violations", v_clk - vc0, 0);
      chk(v_data == vd0, "R6 data change violations", v_data - vd0, 0);
      chk(v_end == ve0, "R7 sync rise after last fall", v_end - ve0, 0);
      if (!hold_next) begin
         @(negedge clk);
         chk(tail_hi == G, "R7 trailing sync high length", tail_hi, G);
         chk(!ser_sync && !ser_clk && req_ready, "R9 idle levels after frame",
             int'(ser_sync), 0);
      end
   endtask

   // ---------------- scenarios
   task automatic t_reset_state();
      rst_n = 1'b0;
      @(negedge clk);
      chk(!ser_sync, "R1 reset sync", int'(ser_sync), 0);
      chk(!ser_clk, "R1 reset sclk", int'(ser_clk), 0);
      chk(!ser_data, "R1 reset data", int'(ser_data), 0);
      chk(!busy && !done, "R1 reset busy/done", int'(busy), 0);
      chk(req_ready, "R1 reset ready", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_patterns();
      run_frame(12'hABC, 2'b01, 1'b0, '0, '0);
      run_frame(12'hFFF, 2'b11, 1'b0, '0, '0);
      run_frame(12'h000, 2'b00, 1'b0, '0, '0);
      run_frame(12'h555, 2'b10, 1'b0, '0, '0);
      run_frame(12'h800, 2'b00, 1'b0, '0, '0);
   endtask

   task automatic t_back_to_back();
      run_frame(12'h3C5, 2'b10, 1'b1, 12'hA5A, 2'b01);
      // now idle with valid still high: next accept at the coming edge
      chk(req_ready && req_valid, "R10 idle with request pending", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && ser_sync, "R10 second frame taken at once", int'(busy), 1);
      chk(tail_hi == G, "R7 first frame trailing high", tail_hi, G);
      while (busy) @(negedge clk);
      chk(gap_lo == 1, "R10 low gap between frames", gap_lo, 1);
      chk(last_word == 16'h1A5A, "R10 second frame word", int'(last_word), 16'h1A5A);
      @(negedge clk);
   endtask

   task automatic t_ignore_busy();
      int rc;
      bit started;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_code = 12'h123; req_mode = 2'b01;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_code = 12'hEEE; req_mode = 2'b11;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      chk(last_word == 16'h1123, "R3 frame unchanged by busy request",
          int'(last_word), 16'h1123);
      @(negedge clk);
      rc = rise_cnt;
      started = 1'b0;
      repeat (30) begin
         @(negedge clk);
         if (busy || ser_sync) started = 1'b1;
      end
      chk(!started, "R3 withdrawn request started nothing", int'(started), 0);
      chk(rise_cnt == rc, "R3 no extra sync pulse", rise_cnt - rc, 0);
   endtask

   task automatic t_reset_mid_frame();
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_code = 12'h777; req_mode = 2'b11;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!ser_sync && !ser_clk && !ser_data, "R1 mid-frame reset lines",
          int'(ser_sync | ser_clk | ser_data), 0);
      chk(req_ready && !busy, "R1 mid-frame reset ready", int'(req_ready), 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_frame(12'h9D2, 2'b10, 1'b0, '0, '0);
   endtask

   // ---------------- watchdog
   initial begin
      repeat (150000) @(posedge clk);
      failed++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      do_reset();
      t_reset_state();
      t_patterns();
      t_back_to_back();
      t_ignore_busy();
      t_reset_mid_frame();
      repeat (5) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule